// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped controller that carries out Clause 22 management transactions toward PHY devices over a two-wire MDC/MDIO pair. Software composes a whole transaction in a single 32-bit command word and writes it to the command offset. That word carries a valid flag, a read or write opcode, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block holds the command as pending until its shift engine takes it. It then serialises a 64-bit frame, drives MDIO from the falling edge of MDC and samples it on the rising edge.

For a read, the block releases MDIO through the turnaround and data phases. It collects the 16 returned bits and two fault flags into a data register, which becomes valid once busy drops. Software polls the status offset: pending must be clear before the next command is written, and busy must be clear before read data is trusted. An 8-bit prescale value P sets the MDC period to 2×(P+1) system clocks.

Top module: `mdio_master`

## Requirements
- R1: Register offsets are status 0x00 (bit 2 pending, bit 3 busy), command 0x08, read data 0x0C and configuration 0x10 (prescale in bits 7:0). Every other offset, the command offset included, reads as zero. After reset, status and data read 0, configuration reads the default prescale of 3, MDC is low and the MDIO output enable is low.
- R2: A command word with bit 31 set and exactly one of bit 2 (read) or bit 1 (write) set, written while pending is clear, makes pending read 1 on the next cycle. Its fields are bits 29:25 PHY address, bits 24:20 register address and bits 19:4 write data.
- R3: A command word with bit 31 clear, or with bits 2 and 1 both set or both clear, leaves pending clear and produces no frame.
- R4: A command word written while pending is set is discarded. Only the earlier command produces a frame.
- R5: The engine takes a pending command at an MDC falling edge. Pending clears and busy sets on the same cycle, and busy clears once the 64th frame bit has been sent.
- R6: The MDC period is 2×(P+1) system clocks. Writing 0 to the prescale field is ignored, and the old value stays in use and reads back.
- R7: A frame is 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the PHY address, the register address, a 2-bit turnaround and 16 data bits, all MSB first. On writes the block drives the turnaround as 10 and the data bits from the command.
- R8: The MDIO output enable is high for frame bits 0 to 45 of every frame and for all 64 bits of a write frame. It is low for bits 46 to 63 of a read frame and low when the block is idle.
- R9: The MDIO output value changes only on cycles where MDC falls. MDIO input is sampled on the cycle MDC rises.
- R10: When a read frame ends, the data register takes the returned bits in 15:0. Bit 16 is set if MDIO was sampled high in the second turnaround bit (no PHY answered). Bit 17 is set if MDIO was sampled low in the first turnaround bit. Bits 31:18 read zero. Write frames leave the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO drive enable, high when the block drives the line |
| mdio_i | input | 1 | MDIO line value as seen by the block |

## Verification
Pending is due on the cycle after the command write edge, so the bench reads status at the following falling clock edge. Busy is due on the same edge that clears pending, so the poll that first sees pending low also checks busy. The data register changes on the edge where busy falls, so it is read at the falling edge where the poll first sees busy low. Frame bits and the output enable are judged by a bench-side PHY model at each MDC rise, with its responses driven at MDC falls, and MDC periods are timed between successive rising edges after a prescale change.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W     = 5;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h10;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

    typedef struct packed {
        logic        ta_first_low;
        logic        ta_second_high;
        logic [15:0] value;
    } rd_result_t;

    typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_t;

    function automatic logic cmd_word_ok(input logic [31:0] w);
        return w[31] && (w[2] ^ w[1]);
    endfunction

    function automatic mdio_cmd_t cmd_unpack(input logic [31:0] w);
        mdio_cmd_t c;
        c.rd    = w[2];
        c.phy   = w[29:25];
        c.regad = w[24:20];
        c.wdata = w[19:4];
        return c;
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_pack(input mdio_cmd_t c);
        return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad,
                (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : c.wdata)};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int PRESCALE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRESCALE_W-1:0] prescale,
    output logic                  mdc,
    output logic                  rise_tick,
    output logic                  fall_tick
);
    logic [PRESCALE_W-1:0] cnt;
    logic                  wrap;

    assign wrap      = (cnt >= prescale);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int PRESCALE_W   = 8,
    parameter int PRESCALE_RST = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  take,
    input  logic                  busy,
    input  logic                  rd_done,
    input  rd_result_t            rd_word,
    output logic                  pending,
    output mdio_cmd_t             cmd,
    output logic [PRESCALE_W-1:0] prescale
);
    rd_result_t            data_q;
    logic [PRESCALE_W-1:0] cfg_q;
    logic                  cmd_wr;
    logic                  cfg_wr;

    assign cmd_wr   = bus_we && (bus_addr == OFS_CMD);
    assign cfg_wr   = bus_we && (bus_addr == OFS_CFG) && (bus_wdata[PRESCALE_W-1:0] != '0);
    assign prescale = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cmd     <= '0;
            data_q  <= '0;
            cfg_q   <= PRESCALE_W'(PRESCALE_RST);
        end else begin
            if (cmd_wr && !pending && cmd_word_ok(bus_wdata)) begin
                pending <= 1'b1;
                cmd     <= cmd_unpack(bus_wdata);
            end else if (take) begin
                pending <= 1'b0;
            end
            if (rd_done)
                data_q <= rd_word;
            if (cfg_wr)
                cfg_q <= bus_wdata[PRESCALE_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STATUS: begin
                bus_rdata[2] = pending;
                bus_rdata[3] = busy;
            end
            OFS_DATA: bus_rdata[17:0] = data_q;
            OFS_CFG:  bus_rdata[PRESCALE_W-1:0] = cfg_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R3: a malformed command word never raises pending
    a_r3_bad_word_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !pending && !cmd_word_ok(bus_wdata)) |=> !pending);

    // R4: a command written while one is pending leaves the held command alone
    a_r4_pending_blocks: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && pending) |=> $stable(cmd));

    // R6: writing zero to the prescale field keeps the old value
    a_r6_zero_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CFG && bus_wdata[PRESCALE_W-1:0] == '0) |=> $stable(cfg_q));

    // R10: read data moves only on the edge that ends a frame
    a_r10_data_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> $fell(busy));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_tick,
    input  logic       fall_tick,
    input  logic       pending,
    input  mdio_cmd_t  cmd,
    input  logic       mdio_i,
    output logic       take,
    output logic       busy,
    output logic       rd_done,
    output rd_result_t rd_word,
    output logic       mdio_o,
    output logic       mdio_oe
);
    eng_state_t            state;
    logic [FRAME_BITS-1:0] sh;
    logic [FRAME_BITS-1:0] frame_w;
    logic [BIT_W-1:0]      bitcnt;
    logic [BIT_W-1:0]      bit_nxt;
    logic                  is_rd;
    logic                  last_bit;
    logic                  fin;
    logic [15:0]           rdsh;
    logic                  e_first;
    logic                  e_second;

    assign frame_w  = frame_pack(cmd);
    assign bit_nxt  = bitcnt + 1'b1;
    assign busy     = (state == ENG_SHIFT);
    assign take     = (state == ENG_IDLE) && pending && fall_tick;
    assign last_bit = (bitcnt == BIT_W'(FRAME_BITS - 1));
    assign fin      = busy && fall_tick && last_bit;
    assign rd_done  = fin && is_rd;
    assign rd_word  = '{ta_first_low: e_first, ta_second_high: e_second, value: rdsh};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            sh       <= '0;
            bitcnt   <= '0;
            is_rd    <= 1'b0;
            rdsh     <= '0;
            e_first  <= 1'b0;
            e_second <= 1'b0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
        end else if (take) begin
            state    <= ENG_SHIFT;
            mdio_o   <= frame_w[FRAME_BITS-1];
            sh       <= {frame_w[FRAME_BITS-2:0], 1'b1};
            bitcnt   <= '0;
            is_rd    <= cmd.rd;
            mdio_oe  <= 1'b1;
            e_first  <= 1'b0;
            e_second <= 1'b0;
        end else if (busy) begin
            if (fall_tick) begin
                if (last_bit) begin
                    state   <= ENG_IDLE;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end else begin
                    bitcnt  <= bit_nxt;
                    mdio_o  <= sh[FRAME_BITS-1];
                    sh      <= {sh[FRAME_BITS-2:0], 1'b1};
                    mdio_oe <= !(is_rd && (bit_nxt >= BIT_W'(TA_POS)));
                end
            end
            if (rise_tick && is_rd) begin
                if (bitcnt == BIT_W'(TA_POS))
                    e_first <= !mdio_i;
                if (bitcnt == BIT_W'(TA_POS + 1))
                    e_second <= mdio_i;
                if (bitcnt >= BIT_W'(DATA_POS))
                    rdsh <= {rdsh[14:0], mdio_i};
            end
        end
    end

    // R5: the cycle pending drops is the cycle the frame starts
    a_r5_take_starts_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> busy);

    // R8: line released through turnaround and data of a read
    a_r8_read_release: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && bitcnt >= BIT_W'(TA_POS)) |-> !mdio_oe);

    // R8: a write frame drives the line throughout
    a_r8_write_drive: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_rd) |-> mdio_oe);

    // R9: the output value moves only when MDC falls
    a_r9_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $past(fall_tick));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int PRESCALE_W   = 8,
    parameter int PRESCALE_RST = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic                  rise_tick;
    logic                  fall_tick;
    logic [PRESCALE_W-1:0] prescale;
    logic                  pending;
    logic                  take;
    logic                  busy;
    logic                  rd_done;
    rd_result_t            rd_word;
    mdio_cmd_t             cmd;

    mdio_clkgen #(.PRESCALE_W(PRESCALE_W)) clkgen_i (
        .clk       (clk),
        .rst       (rst),
        .prescale  (prescale),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_regs #(.PRESCALE_W(PRESCALE_W), .PRESCALE_RST(PRESCALE_RST)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .take      (take),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_word   (rd_word),
        .pending   (pending),
        .cmd       (cmd),
        .prescale  (prescale)
    );

    mdio_frame_eng eng_i (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .pending   (pending),
        .cmd       (cmd),
        .mdio_i    (mdio_i),
        .take      (take),
        .busy      (busy),
        .rd_done   (rd_done),
        .rd_word   (rd_word),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    import mdio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, dut_o, dut_oe, mdio_line;
    logic        phy_en = 1'b0, phy_val = 1'b1;
    int          phy_mode = 0;
    int          total = 0, bad = 0;
    int          frames_seen = 0;
    bit          done = 1'b0;

    typedef struct {
        bit        rd;
        bit [4:0]  phy;
        bit [4:0]  ra;
        bit [15:0] wd;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;  // 4 time units: 250 MHz

    assign mdio_line = dut_oe ? dut_o : (phy_en ? phy_val : 1'b1);

    mdio_master dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(dut_o), .mdio_oe(dut_oe), .mdio_i(mdio_line)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] resp_of(input logic [4:0] p, input logic [4:0] r);
        return {p, r, 6'h15} ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] cmd_word(input bit rd, input bit [4:0] p, input bit [4:0] r, input bit [15:0] w);
        return {1'b1, 1'b0, p, r, w, 1'b0, rd, ~rd, 1'b0};
    endfunction

    // PHY model and frame monitor (scoreboard consumer)
    int          pos = -1, ones = 0;
    logic [63:0] fbits;
    bit          oe_bad, r9_bad, rd_now;
    logic        prev_mdc = 1'b0, prev_o = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            pos = -1; ones = 0; phy_en = 1'b0;
            prev_mdc = 1'b0; prev_o = 1'b1;
        end else begin
            if (dut_o !== prev_o && !(prev_mdc && !mdc)) r9_bad = 1'b1;
            if (mdc && !prev_mdc) begin
                if (pos < 0) begin
                    if (!mdio_line && ones >= 32) begin
                        pos = 32; fbits = '1; fbits[31] = 1'b0;
                        oe_bad = 1'b0; r9_bad = 1'b0;
                    end else begin
                        ones = mdio_line ? ones + 1 : 0;
                    end
                end else begin
                    pos++;
                    fbits[63-pos] = mdio_line;
                    rd_now = (pos > 35) && fbits[29] && !fbits[28];
                    if (dut_oe !== !(rd_now && pos >= 46)) oe_bad = 1'b1;
                    if (pos == 63) begin
                        exp_t e;
                        logic [1:0]  ta_e;
                        logic [31:0] act, expv;
                        frames_seen++;
                        if (q.size() == 0) begin
                            chk(1'b0, "R7 unexpected frame", fbits[31:0], 32'h0);
                        end else begin
                            e = q.pop_front();
                            ta_e = !e.rd ? 2'b10 : (phy_mode == 1 ? 2'b11 : (phy_mode == 2 ? 2'b00 : 2'b10));
                            act  = {fbits[31:16], e.rd ? 16'h0 : fbits[15:0]};
                            expv = {2'b01, e.rd ? 2'b10 : 2'b01, e.phy, e.ra, ta_e, e.rd ? 16'h0 : e.wd};
                            chk(act == expv, "R7 frame fields", act, expv);
                            chk(!oe_bad, "R8 output enable per bit", {31'b0, oe_bad}, 32'h0);
                            chk(!r9_bad, "R9 output moves on MDC fall", {31'b0, r9_bad}, 32'h0);
                        end
                        pos = -1; ones = 0;
                    end
                end
            end else if (!mdc && prev_mdc) begin
                phy_en = 1'b0;
                if (pos >= 45 && pos <= 62 && fbits[29] && !fbits[28] && phy_mode != 1) begin
                    if (pos == 45) begin
                        if (phy_mode == 2) begin phy_en = 1'b1; phy_val = 1'b0; end
                    end else if (pos == 46) begin
                        phy_en = 1'b1; phy_val = 1'b0;
                    end else begin
                        phy_en = 1'b1;
                        phy_val = resp_of(fbits[27:23], fbits[22:18])[62-pos];
                    end
                end
            end
            prev_mdc = mdc; prev_o = dut_o;
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] rv;
        bus_read(OFS_STATUS, rv);
        while (rv[2]) begin @(negedge clk); bus_read(OFS_STATUS, rv); end
        chk(rv[3] == 1'b1, "R5 busy set when pending clears", rv, 32'h8);
        while (rv[3]) begin @(negedge clk); bus_read(OFS_STATUS, rv); end
    endtask

    // scoreboard producer: push expectation, send command, wait for completion
    task automatic issue(input bit rd, input bit [4:0] p, input bit [4:0] r, input bit [15:0] w);
        exp_t e;
        logic [31:0] rv;
        e.rd = rd; e.phy = p; e.ra = r; e.wd = w;
        q.push_back(e);
        bus_write(OFS_CMD, cmd_word(rd, p, r, w));
        bus_read(OFS_STATUS, rv);
        chk(rv[2] == 1'b1, "R2 pending after command", rv, 32'h4);
        @(negedge clk);
        wait_idle();
    endtask

    task automatic mdc_period(output int per);
        time t0;
        @(posedge mdc);
        t0 = $time;
        @(posedge mdc);
        per = int'(($time - t0) / 4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int per, fs;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and map
        bus_read(OFS_STATUS, rv); chk(rv == 32'h0, "R1 status after reset", rv, 32'h0);
        bus_read(OFS_DATA, rv);   chk(rv == 32'h0, "R1 data after reset", rv, 32'h0);
        bus_read(OFS_CFG, rv);    chk(rv == 32'h3, "R1 prescale after reset", rv, 32'h3);
        bus_read(OFS_CMD, rv);    chk(rv == 32'h0, "R1 command offset reads zero", rv, 32'h0);
        bus_read(5'h04, rv);      chk(rv == 32'h0, "R1 unused offset reads zero", rv, 32'h0);
        chk(dut_oe == 1'b0, "R1 output enable low after reset", {31'b0, dut_oe}, 32'h0);

        // R3 malformed words
        bus_write(OFS_CMD, 32'h0000_0004);
        bus_read(OFS_STATUS, rv); chk(rv[2] == 1'b0, "R3 valid clear ignored", rv, 32'h0);
        bus_write(OFS_CMD, 32'h8000_0006);
        bus_read(OFS_STATUS, rv); chk(rv[2] == 1'b0, "R3 both opcodes ignored", rv, 32'h0);
        bus_write(OFS_CMD, 32'h8000_0000);
        bus_read(OFS_STATUS, rv); chk(rv[2] == 1'b0, "R3 no opcode ignored", rv, 32'h0);
        repeat (600) @(negedge clk);
        chk(frames_seen == 0, "R3 no frame from ignored words", frames_seen, 0);
        bus_read(OFS_STATUS, rv); chk(rv == 32'h0, "R3 still idle", rv, 32'h0);

        // write frame, then data register untouched (R10)
        issue(1'b0, 5'h11, 5'h04, 16'hBEEF);
        bus_read(OFS_DATA, rv); chk(rv == 32'h0, "R10 write leaves data", rv, 32'h0);

        // normal read
        phy_mode = 0;
        issue(1'b1, 5'h03, 5'h1F, 16'h0);
        bus_read(OFS_DATA, rv);
        chk(rv == {16'h0, resp_of(5'h03, 5'h1F)}, "R10 read data", rv, {16'h0, resp_of(5'h03, 5'h1F)});

        issue(1'b0, 5'h1E, 5'h0A, 16'h1234);
        bus_read(OFS_DATA, rv);
        chk(rv == {16'h0, resp_of(5'h03, 5'h1F)}, "R10 data kept over write", rv, {16'h0, resp_of(5'h03, 5'h1F)});

        // no PHY answers
        phy_mode = 1;
        issue(1'b1, 5'h08, 5'h02, 16'h0);
        bus_read(OFS_DATA, rv); chk(rv == 32'h0001_FFFF, "R10 absent PHY flag", rv, 32'h0001_FFFF);

        // first turnaround pulled low
        phy_mode = 2;
        issue(1'b1, 5'h15, 5'h11, 16'h0);
        bus_read(OFS_DATA, rv);
        chk(rv == {16'h0002, resp_of(5'h15, 5'h11)}, "R10 turnaround fault flag", rv, {16'h0002, resp_of(5'h15, 5'h11)});
        phy_mode = 0;

        // R4 second command while pending
        fs = frames_seen;
        begin
            exp_t e;
            e.rd = 1'b1; e.phy = 5'h07; e.ra = 5'h02; e.wd = 16'h0;
            q.push_back(e);
        end
        bus_write(OFS_CMD, cmd_word(1'b1, 5'h07, 5'h02, 16'h0));
        bus_write(OFS_CMD, cmd_word(1'b0, 5'h09, 5'h09, 16'hAAAA));
        wait_idle();
        repeat (600) @(negedge clk);
        chk(frames_seen == fs + 1, "R4 one frame only", frames_seen, fs + 1);
        chk(q.size() == 0, "R4 scoreboard drained", q.size(), 0);
        bus_read(OFS_DATA, rv);
        chk(rv == {16'h0, resp_of(5'h07, 5'h02)}, "R4 first command kept", rv, {16'h0, resp_of(5'h07, 5'h02)});

        // R6 MDC period
        mdc_period(per); chk(per == 8, "R6 period at P=3", per, 8);
        bus_write(OFS_CFG, 32'h0);
        bus_read(OFS_CFG, rv); chk(rv == 32'h3, "R6 zero prescale ignored", rv, 32'h3);
        mdc_period(per); mdc_period(per); chk(per == 8, "R6 period kept after zero", per, 8);
        bus_write(OFS_CFG, 32'h1);
        mdc_period(per); mdc_period(per); chk(per == 4, "R6 period at P=1", per, 4);
        @(negedge clk);
        issue(1'b0, 5'h02, 5'h1C, 16'h5A5A);
        bus_write(OFS_CFG, 32'd20);
        bus_read(OFS_CFG, rv); chk(rv == 32'd20, "R6 prescale readback", rv, 32'd20);
        mdc_period(per); mdc_period(per); chk(per == 42, "R6 period at P=20", per, 42);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule